// File: doc/BRIEF.md
# Hexagon Tracking and Transition Controller

This block runs once per sampling period of a three-level space-vector modulator and decides which of six overlapping hexagons of the voltage plane that period may draw its vectors from. The reference angle arrives as an unsigned count of a full turn, where one turn is `6*SIX` counts and one hexagon pitch is `SIX` counts. On every period strobe, the block rotates the reference into the frame of the period's hexagon. It then decides whether the hexagon can stay the same, and it publishes the result for the sequence generator downstream.

The tracker is a three-state machine: `TRK_STEADY`, `TRK_STEP_UP` and `TRK_STEP_DOWN`. On every strobe it moves to one of these states from any state. It goes to `TRK_STEP_UP` when the rotated reference lies beyond the counter-clockwise threshold of half a pitch. It goes to `TRK_STEP_DOWN` when the reference lies beyond the matching clockwise threshold. Otherwise it goes to `TRK_STEADY`.

A step state tells the sequence generator that the current period's vector sequence must end on the centre of the adjacent hexagon. The hexagon index then moves by one, modulo 6, for the following period. If the reference lies beyond the adjacent hexagon's own half pitch, it has skipped the overlap zone. In that case the block still steps only one hexagon, so commutations stay adjacent, and it raises a flag that the full reference is not produced.

A second two-state machine picks the modulation mode from the modulation index, using hysteresis. `MODE_3L` moves to `MODE_2L` when the index falls below `THR-HYST`. `MODE_2L` moves back to `MODE_3L` when the index reaches `THR+HYST`.

Top module: `hexsel_top`

## Requirements
- R1: After reset, the outputs are: hexagon 0, rotated angle 0, no step request, limit flag low, three-level mode (`mode_2l_o` = 0).
- R2: When the strobe is low, every output holds its value, whatever the angle and index inputs do.
- R3: On a strobe, `rot_angle_o` becomes (angle − h·SIX) mod 6·SIX, where h is the hexagon that `hex_o` shows for that same period.
- R4: Let d be the rotated angle taken as signed in [−3·SIX, 3·SIX). If |d| ≤ SIX/2, no step is requested and the next period keeps the same hexagon.
- R5: If SIX/2 < d ≤ 3·SIX/2, `step_up_o` is 1, `limited_o` is 0, and the next period's hexagon is h+1 mod 6.
- R6: If −3·SIX/2 ≤ d < −SIX/2, `step_down_o` is 1, `limited_o` is 0, and the next period's hexagon is h−1 mod 6.
- R7: If d > 3·SIX/2 or d < −3·SIX/2, `limited_o` is 1. The step follows the sign of d, and the hexagon still moves by exactly one.
- R8: `hex_o` stays within 0..5 and wraps 5→0 going up and 0→5 going down. Between consecutive periods it changes by at most one position.
- R9: `mode_2l_o` (1 = two-level, 0 = three-level) is set on a strobe when the index is below THR−HYST. It is cleared on a strobe when the index is at or above THR+HYST. For any index in between, it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_i | input | 1 | One-cycle start of a sampling period |
| angle_i | input | ANG_W | Reference angle, 0..6·SIX−1 counts per turn |
| mindex_i | input | MI_W | Modulation index as a fraction of 2^MI_W |
| hex_o | output | 3 | Hexagon used in the current period |
| rot_angle_o | output | ANG_W | Reference rotated into hexagon 0's frame |
| step_up_o | output | 1 | End this period on the next hexagon's centre (counter-clockwise) |
| step_down_o | output | 1 | End this period on the previous hexagon's centre (clockwise) |
| limited_o | output | 1 | Reference skipped the overlap; output is reduced |
| mode_2l_o | output | 1 | 1 = two-level mode, 0 = three-level mode |

## Verification
A slow counter-clockwise sweep over two full turns, and a matching clockwise sweep, show that thresholds are crossed at the right count and that the index wraps correctly in both directions. Large angle jumps separate a proper overlap transition from a limited single step. They also reveal a block that wrongly jumps several hexagons at once. Points placed exactly on the half-pitch threshold and one count past it pin down the comparison's edge. An index walk through the hysteresis band shows that the mode holds inside the band and switches at each band edge. Changing the inputs between strobes shows that the outputs hold.

// File: rtl/hexsel_pkg.sv
package hexsel_pkg;

    typedef enum logic [1:0] {
        TRK_STEADY    = 2'd0,
        TRK_STEP_UP   = 2'd1,
        TRK_STEP_DOWN = 2'd2
    } trk_state_t;

    typedef enum logic {
        MODE_3L = 1'b0,
        MODE_2L = 1'b1
    } mode_t;

    function automatic logic [2:0] hex_inc(input logic [2:0] h);
        return (h == 3'd5) ? 3'd0 : h + 3'd1;
    endfunction

    function automatic logic [2:0] hex_dec(input logic [2:0] h);
        return (h == 3'd0) ? 3'd5 : h - 3'd1;
    endfunction

endpackage

// File: rtl/hexsel_tracker.sv
module hexsel_tracker
    import hexsel_pkg::*;
#(
    parameter int SIX   = 512,
    parameter int ANG_W = $clog2(6 * SIX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    input  logic [ANG_W-1:0] angle_i,
    output logic [2:0]       hex_o,
    output logic [ANG_W-1:0] rot_o,
    output trk_state_t       state_o,
    output logic             limited_o
);
    localparam int TURN = 6 * SIX;
    localparam int HALF = SIX / 2;
    localparam int SW   = ANG_W + 1;

    trk_state_t       st_q, st_d;
    logic [2:0]       pend_q;
    logic [2:0]       hex_q;
    logic [ANG_W-1:0] rot_q;
    logic             lim_q;

    logic [SW-1:0]    offset, wrapped;
    logic [ANG_W-1:0] rel;
    logic             fwd_half, go_up, go_down, jump;

    // rotate the reference into the frame of the pending hexagon
    always_comb begin
        offset  = SW'(SIX) * SW'(pend_q);
        wrapped = ({1'b0, angle_i} + SW'(TURN)) - offset;
        rel     = (wrapped >= SW'(TURN)) ? ANG_W'(wrapped - SW'(TURN))
                                         : ANG_W'(wrapped);
        fwd_half = rel < ANG_W'(TURN / 2);
        go_up    = fwd_half && (rel > ANG_W'(HALF));
        go_down  = !fwd_half && (rel < ANG_W'(TURN - HALF));
        jump     = (fwd_half && (rel > ANG_W'(3 * HALF))) ||
                   (!fwd_half && (rel < ANG_W'(TURN - 3 * HALF)));
        if (go_up)        st_d = TRK_STEP_UP;
        else if (go_down) st_d = TRK_STEP_DOWN;
        else              st_d = TRK_STEADY;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)        st_q <= TRK_STEADY;
        else if (strobe_i) st_q <= st_d;
    end

    // period outputs and pending hexagon
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 3'd0;
            hex_q  <= 3'd0;
            rot_q  <= '0;
            lim_q  <= 1'b0;
        end else if (strobe_i) begin
            hex_q <= pend_q;
            rot_q <= rel;
            lim_q <= jump;
            unique case (st_d)
                TRK_STEADY:    pend_q <= pend_q;
                TRK_STEP_UP:   pend_q <= hex_inc(pend_q);
                TRK_STEP_DOWN: pend_q <= hex_dec(pend_q);
                default:       pend_q <= pend_q;
            endcase
        end
    end

    assign hex_o     = hex_q;
    assign rot_o     = rot_q;
    assign state_o   = st_q;
    assign limited_o = lim_q;

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> ($stable(hex_o) && $stable(rot_o) && $stable(state_o) && $stable(limited_o)));

    a_r5_up_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && st_q == TRK_STEP_UP) |=> hex_o == hex_inc($past(hex_o)));

    a_r6_down_retreats: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && st_q == TRK_STEP_DOWN) |=> hex_o == hex_dec($past(hex_o)));

    a_r4_steady_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && st_q == TRK_STEADY) |=> $stable(hex_o));

    a_r7_limit_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
        limited_o |-> state_o != TRK_STEADY);

    a_r8_hex_range: assert property (@(posedge clk) disable iff (!rst_n)
        hex_o <= 3'd5);

endmodule

// File: rtl/hexsel_mode.sv
module hexsel_mode
    import hexsel_pkg::*;
#(
    parameter int MI_W = 10,
    parameter int THR  = 320,
    parameter int HYST = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strobe_i,
    input  logic [MI_W-1:0] mindex_i,
    output mode_t           mode_o
);
    localparam logic [MI_W-1:0] LO = MI_W'(THR - HYST);
    localparam logic [MI_W-1:0] HI = MI_W'(THR + HYST);

    mode_t mode_q, mode_d;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_3L: if (mindex_i < LO)  mode_d = MODE_2L;
            MODE_2L: if (mindex_i >= HI) mode_d = MODE_3L;
            default: mode_d = MODE_3L;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        mode_q <= MODE_3L;
        else if (strobe_i) mode_q <= mode_d;
    end

    assign mode_o = mode_q;

    a_r9_enter_2l: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && mindex_i < LO) |=> mode_o == MODE_2L);

    a_r9_enter_3l: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && mindex_i >= HI) |=> mode_o == MODE_3L);

    a_r9_band_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && mindex_i >= LO && mindex_i < HI) |=> $stable(mode_o));

    a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> $stable(mode_o));

endmodule

// File: rtl/hexsel_top.sv
module hexsel_top
    import hexsel_pkg::*;
#(
    parameter int SIX   = 512,
    parameter int MI_W  = 10,
    parameter int THR   = 320,
    parameter int HYST  = 4,
    parameter int ANG_W = $clog2(6 * SIX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    input  logic [ANG_W-1:0] angle_i,
    input  logic [MI_W-1:0]  mindex_i,
    output logic [2:0]       hex_o,
    output logic [ANG_W-1:0] rot_angle_o,
    output logic             step_up_o,
    output logic             step_down_o,
    output logic             limited_o,
    output logic             mode_2l_o
);
    trk_state_t trk_st;
    mode_t      mode;

    hexsel_tracker #(.SIX(SIX), .ANG_W(ANG_W)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_i  (strobe_i),
        .angle_i   (angle_i),
        .hex_o     (hex_o),
        .rot_o     (rot_angle_o),
        .state_o   (trk_st),
        .limited_o (limited_o)
    );

    hexsel_mode #(.MI_W(MI_W), .THR(THR), .HYST(HYST)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (strobe_i),
        .mindex_i (mindex_i),
        .mode_o   (mode)
    );

    assign step_up_o   = (trk_st == TRK_STEP_UP);
    assign step_down_o = (trk_st == TRK_STEP_DOWN);
    assign mode_2l_o   = (mode == MODE_2L);

    a_r8_adjacent_only: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> (hex_o == $past(hex_o) || hex_o == hex_inc($past(hex_o)) ||
                      hex_o == hex_dec($past(hex_o))));

    a_r5_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_up_o, step_down_o}));

endmodule

// File: tb/test_hexsel_top.sv
module test_hexsel_top;
    localparam int SIX   = 512;
    localparam int TURN  = 6 * SIX;
    localparam int HALF  = SIX / 2;
    localparam int ANG_W = $clog2(TURN);
    localparam int MI_W  = 10;
    localparam int THR   = 320;
    localparam int HYST  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             strobe = 1'b0;
    logic [ANG_W-1:0] angle = '0;
    logic [MI_W-1:0]  mindex = '0;
    logic [2:0]       hex;
    logic [ANG_W-1:0] rot;
    logic             up, dn, lim, m2l;

    int checks = 0;
    int fails  = 0;

    // reference model state
    int m_pend = 0, m_hex = 0, m_rot = 0, m_up = 0, m_dn = 0, m_lim = 0, m_mode = 0;
    bit last_strobe = 1'b0;

    always #2 clk = ~clk;

    hexsel_top #(.SIX(SIX), .MI_W(MI_W), .THR(THR), .HYST(HYST)) i_hexsel_top (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .angle_i(angle), .mindex_i(mindex),
        .hex_o(hex), .rot_angle_o(rot), .step_up_o(up), .step_down_o(dn),
        .limited_o(lim), .mode_2l_o(m2l)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        int cur, rel, d;
        if (!rst_n) begin
            m_pend = 0; m_hex = 0; m_rot = 0; m_up = 0; m_dn = 0; m_lim = 0; m_mode = 0;
        end else if (strobe) begin
            cur = m_pend;
            rel = ((int'(angle) - cur * SIX) % TURN + TURN) % TURN;
            d   = (rel < TURN / 2) ? rel : rel - TURN;
            m_hex = cur;
            m_rot = rel;
            m_up  = (d > HALF) ? 1 : 0;
            m_dn  = (d < -HALF) ? 1 : 0;
            m_lim = (d > 3 * HALF || d < -3 * HALF) ? 1 : 0;
            if (m_up == 1)      m_pend = (cur + 1) % 6;
            else if (m_dn == 1) m_pend = (cur + 5) % 6;
            if (int'(mindex) < THR - HYST)       m_mode = 1;
            else if (int'(mindex) >= THR + HYST) m_mode = 0;
        end
        last_strobe = strobe;
    endtask

    // one clock: model follows the edge, outputs are compared at the falling edge
    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (rst_n) begin
            if (last_strobe) begin
                chk("R8 hex", int'(hex), m_hex);
                chk("R3 rot", int'(rot), m_rot);
                chk("R5 up", int'(up), m_up);
                chk("R6 down", int'(dn), m_dn);
                chk("R7 limited", int'(lim), m_lim);
                chk("R9 mode", int'(m2l), m_mode);
            end else begin
                chk("R2 hold hex", int'(hex), m_hex);
                chk("R2 hold rot", int'(rot), m_rot);
                chk("R2 hold up", int'(up), m_up);
                chk("R2 hold down", int'(dn), m_dn);
                chk("R2 hold limited", int'(lim), m_lim);
                chk("R2 hold mode", int'(m2l), m_mode);
            end
        end
    endtask

    // one sampling period: strobe cycle then idle cycles with disturbed inputs
    task automatic period(input int ang, input int mi);
        strobe = 1'b1;
        angle  = ANG_W'(ang);
        mindex = MI_W'(mi);
        tick();
        strobe = 1'b0;
        angle  = ANG_W'((ang + 1111) % TURN);
        mindex = MI_W'(mi ^ 10'h155);
        tick();
        tick();
    endtask

    initial begin
        int a;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 hex", int'(hex), 0);
        chk("R1 rot", int'(rot), 0);
        chk("R1 req", int'({up, dn}), 0);
        chk("R1 limited", int'(lim), 0);
        chk("R1 mode", int'(m2l), 0);

        // R4 exactly on threshold: no step
        period(HALF, 500);
        chk("R4 no step at threshold", int'(up), 0);
        period(HALF, 500);
        chk("R4 hex kept", int'(hex), 0);
        // R5 one count past threshold
        period(HALF + 1, 500);
        chk("R5 step up", int'(up), 1);
        chk("R5 not limited", int'(lim), 0);
        period(HALF + 1, 500);
        chk("R5 hex advanced", int'(hex), 1);
        chk("R3 rotated", int'(rot), HALF + 1 - SIX + TURN);
        // R7 jump past the overlap
        period(2000, 500);
        chk("R7 limited", int'(lim), 1);
        chk("R7 step up on jump", int'(up), 1);
        period(2000, 500);
        chk("R7 single step", int'(hex), 2);

        // counter-clockwise sweep, two turns
        a = 2000;
        for (int k = 0; k < 160; k++) begin
            a = (a + 40) % TURN;
            period(a, 500);
        end
        // clockwise sweep, two turns
        for (int k = 0; k < 160; k++) begin
            a = (a - 40 + TURN) % TURN;
            period(a, 500);
        end
        // jumps in both directions
        period(a, 500);
        period((a + 1000) % TURN, 500);
        period((a + 1000) % TURN, 500);
        period((a + 1600) % TURN, 500);
        period((a + 2500) % TURN, 500);
        period((a + 2500) % TURN, 500);
        period((a + 2500) % TURN, 500);
        period((a + 2500) % TURN, 500);

        // R9 hysteresis walk
        period(a, 319); chk("R9 band keeps 3L", int'(m2l), 0);
        period(a, 316); chk("R9 lower edge keeps 3L", int'(m2l), 0);
        period(a, 315); chk("R9 below band -> 2L", int'(m2l), 1);
        period(a, 318); chk("R9 band keeps 2L", int'(m2l), 1);
        period(a, 323); chk("R9 upper edge keeps 2L", int'(m2l), 1);
        period(a, 324); chk("R9 at upper edge -> 3L", int'(m2l), 0);
        period(a, 0);   chk("R9 zero -> 2L", int'(m2l), 1);
        period(a, 1023); chk("R9 full -> 3L", int'(m2l), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
        $finish;
    end

endmodule